// File: doc/BRIEF.md
# Bounded Float-to-Integral Rounding Unit

This unit takes one IEEE-754 operand, either single or double precision, and rounds it to an integral floating-point value. It then checks that the rounded value fits a signed 32-bit or 64-bit integer range. A value that is in range comes out as the rounded float. A value that is out of range comes out as the most negative integer of the selected width, encoded as a float of the operand's precision. The unit raises an invalid flag in that case and clears inexact.

A variant select forces rounding toward zero. Otherwise the unit uses the 2-bit current rounding mode. The unit is a single registered stage: an operand presented with `in_valid` produces its result, with `out_valid`, one clock later. While `in_valid` is low, the registered result and flags hold their last values. Single-precision operands sit in the low 32 bits of `operand`, and their results come back zero-extended in `result`.

Top module: `fp_int_bound_round`

## Requirements
- R1: `out_valid` equals `in_valid` of the previous cycle. `result`, `flag_invalid` and `flag_inexact` change only in the cycle after `in_valid` was high, and otherwise hold.
- R2: An operand whose biased exponent field is all ones (NaN or infinity) always gives the out-of-range outcome, whatever its sign and fraction.
- R3: The range test uses the biased exponent of the rounded value. If that exponent is below the limit (126+N for single, 1022+N for double, where N is 32 or 64), the rounded value is the result with invalid low.
- R4: A rounded value whose exponent equals the limit is accepted only if its sign is 1 and its fraction is zero, which is exactly -2^(N-1). Any other value at or above the limit is out of range.
- R5: The out-of-range result has sign 1, biased exponent equal to the limit, and fraction 0. `flag_invalid` is 1 and `flag_inexact` is 0, even when the rounding step was inexact.
- R6: With `trunc_sel`=1 the unit rounds toward zero whatever `rmode` says. With `trunc_sel`=0 it uses `rmode`: 0 rounds to nearest, 1 rounds toward +infinity, 2 rounds toward -infinity, and 3 rounds toward zero.
- R7: In round-to-nearest mode, a value exactly halfway between two integers goes to the even one.
- R8: For an in-range result, `flag_inexact` is 1 exactly when the result differs from the operand. Zeros and already-integral values pass through bit for bit, and a signed zero keeps its sign.
- R9: A nonzero operand with magnitude below one gives a zero carrying the operand's sign. It gives +1 or -1 only when the mode requires it: above one half in nearest mode, a positive value toward +infinity, or a negative value toward -infinity.
- R10: For single precision (`is_double`=0) the operand is `operand[31:0]` and `result[63:32]` is zero. `int64_sel`=1 is legal for single precision and moves the limit to 190.
- R11: During reset `out_valid`, `result`, `flag_invalid` and `flag_inexact` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand and controls are valid this cycle |
| operand | input | 64 | Float operand; single precision uses bits 31:0 |
| is_double | input | 1 | 1 = double precision, 0 = single precision |
| int64_sel | input | 1 | 1 = 64-bit integer range, 0 = 32-bit |
| trunc_sel | input | 1 | 1 = force rounding toward zero |
| rmode | input | 2 | Current rounding mode (0 nearest-even, 1 up, 2 down, 3 zero) |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 64 | Integral float result, zero-extended for single |
| flag_invalid | output | 1 | Out-of-range or NaN/infinity operand |
| flag_inexact | output | 1 | In-range result differs from operand |

## Verification
The bench aims at the limit exponent, where a design that tests the input exponent instead of the rounded one would accept 2147483647.5, which rounds up to 2^31. A design that tests the exponent alone would reject the legal value -2^31. Halfway values of both parities and sub-one magnitudes in every mode probe the rounding increment and carry. A wrong tie rule gives an odd integer. A lost sign gives +0 for a negative fraction. A missing carry into the exponent turns 1.5 into 1.0 in place of 2.0. Out-of-range cases built from inexact inputs catch a design that leaks inexact alongside invalid. Single-precision operands with junk in the upper bits catch a design that fails to zero-extend.

// File: rtl/fir_pkg.sv
package fir_pkg;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'd0,
        RM_UP        = 2'd1,
        RM_DOWN      = 2'd2,
        RM_ZERO      = 2'd3
    } rmode_e;

    localparam int SP_EW = 8;
    localparam int SP_FW = 23;
    localparam int DP_EW = 11;
    localparam int DP_FW = 52;
    localparam int NUM_FMT = 2;
    localparam int XLEN = 64;

endpackage

// File: rtl/fir_round.sv
module fir_round
    import fir_pkg::*;
#(
    parameter int EW = 8,
    parameter int FW = 23
) (
    input  logic [EW+FW:0] op,
    input  rmode_e         mode,
    output logic [EW+FW:0] rnd,
    output logic           inexact,
    output logic           special
);
    localparam int BIAS = (1 << (EW - 1)) - 1;
    localparam int MW   = FW + 2;
    localparam logic [EW-1:0] INT_EXP  = EW'(BIAS + FW);
    localparam logic [EW-1:0] ONE_EXP  = EW'(BIAS);
    localparam logic [EW-1:0] HALF_EXP = EW'(BIAS - 1);

    logic          sgn;
    logic [EW-1:0] ex;
    logic [FW-1:0] fr;
    logic [MW-1:0] mant, one, mask, half, keep_m, rem, sum;
    logic [EW:0]   shamt;
    logic          up, lsb, carry;
    logic          sum_lead_unused;

    assign sgn  = op[EW+FW];
    assign ex   = op[EW+FW-1:FW];
    assign fr   = op[FW-1:0];
    assign mant = {2'b01, fr};
    assign sum_lead_unused = sum[FW];

    always_comb begin
        rnd     = op;
        inexact = 1'b0;
        special = &ex;
        up      = 1'b0;
        shamt   = {1'b0, INT_EXP} - {1'b0, ex};
        one     = MW'(1) << shamt;
        mask    = one - MW'(1);
        half    = one >> 1;
        keep_m  = mant & ~mask;
        rem     = mant & mask;
        lsb     = |(mant & one);
        sum     = keep_m;
        carry   = 1'b0;
        if (special || ex >= INT_EXP) begin
            rnd = op;
        end else if (ex < ONE_EXP) begin
            if (ex != '0 || fr != '0) begin
                inexact = 1'b1;
                unique case (mode)
                    RM_NEAR_EVEN: up = (ex == HALF_EXP) && (fr != '0);
                    RM_UP:        up = !sgn;
                    RM_DOWN:      up = sgn;
                    RM_ZERO:      up = 1'b0;
                endcase
                rnd = up ? {sgn, ONE_EXP, {FW{1'b0}}} : {sgn, {(EW+FW){1'b0}}};
            end
        end else begin
            inexact = (rem != '0);
            unique case (mode)
                RM_NEAR_EVEN: up = (rem > half) || ((rem == half) && lsb);
                RM_UP:        up = !sgn && inexact;
                RM_DOWN:      up = sgn && inexact;
                RM_ZERO:      up = 1'b0;
            endcase
            sum   = keep_m + (up ? one : '0);
            carry = sum[FW+1];
            rnd   = {sgn, ex + EW'(carry), sum[FW-1:0]};
        end
    end

endmodule

// File: rtl/fir_range.sv
module fir_range #(
    parameter int EW = 8,
    parameter int FW = 23
) (
    input  logic [EW+FW:0] rnd,
    input  logic           special,
    input  logic           int64_sel,
    output logic           in_range,
    output logic [EW+FW:0] minint
);
    localparam int BIAS = (1 << (EW - 1)) - 1;
    localparam logic [EW-1:0] LIM32 = EW'(BIAS - 1 + 32);
    localparam logic [EW-1:0] LIM64 = EW'(BIAS - 1 + 64);

    logic [EW-1:0] lim;
    logic [EW-1:0] rex;

    assign lim    = int64_sel ? LIM64 : LIM32;
    assign rex    = rnd[EW+FW-1:FW];
    assign minint = {1'b1, lim, {FW{1'b0}}};

    always_comb begin
        if (special)
            in_range = 1'b0;
        else if (rex < lim)
            in_range = 1'b1;
        else if (rex == lim)
            in_range = rnd[EW+FW] && (rnd[FW-1:0] == '0);
        else
            in_range = 1'b0;
    end

endmodule

// File: rtl/fp_int_bound_round.sv
module fp_int_bound_round
    import fir_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [63:0] operand,
    input  logic        is_double,
    input  logic        int64_sel,
    input  logic        trunc_sel,
    input  logic [1:0]  rmode,
    output logic        out_valid,
    output logic [63:0] result,
    output logic        flag_invalid,
    output logic        flag_inexact
);
    rmode_e eff_mode;
    logic [NUM_FMT-1:0][XLEN-1:0] fmt_res;
    logic [NUM_FMT-1:0]           fmt_inv;
    logic [NUM_FMT-1:0]           fmt_inx;
    logic [XLEN-1:0]              nxt_res;
    logic                         nxt_inv, nxt_inx;

    assign eff_mode = trunc_sel ? RM_ZERO : rmode_e'(rmode);

    for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
        localparam int EW = (g == 1) ? DP_EW : SP_EW;
        localparam int FW = (g == 1) ? DP_FW : SP_FW;
        localparam int W  = 1 + EW + FW;
        logic [W-1:0] rnd_v, min_v;
        logic         inx_v, spc_v, ok_v;

        fir_round #(.EW(EW), .FW(FW)) u_round (
            .op(operand[W-1:0]), .mode(eff_mode),
            .rnd(rnd_v), .inexact(inx_v), .special(spc_v)
        );
        fir_range #(.EW(EW), .FW(FW)) u_range (
            .rnd(rnd_v), .special(spc_v), .int64_sel(int64_sel),
            .in_range(ok_v), .minint(min_v)
        );
        assign fmt_res[g] = ok_v ? XLEN'(rnd_v) : XLEN'(min_v);
        assign fmt_inv[g] = !ok_v;
        assign fmt_inx[g] = ok_v && inx_v;
    end

    assign nxt_res = fmt_res[is_double];
    assign nxt_inv = fmt_inv[is_double];
    assign nxt_inx = fmt_inx[is_double];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            result       <= '0;
            flag_invalid <= 1'b0;
            flag_inexact <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result       <= nxt_res;
                flag_invalid <= nxt_inv;
                flag_inexact <= nxt_inx;
            end
        end
    end

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R1
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result) && $stable(flag_invalid) && $stable(flag_inexact));
    // R2
    special_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (is_double ? (&operand[62:52]) : (&operand[30:23])) |=> flag_invalid);
    // R5
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(flag_invalid && flag_inexact));
    // R5
    oor_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && flag_invalid |->
            ($past(is_double) ? (result[63] && result[51:0] == '0)
                              : (result[31] && result[22:0] == '0)));
    // R8
    exact_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !flag_invalid && !flag_inexact |->
            result == ($past(is_double) ? $past(operand) : {32'b0, $past(operand[31:0])}));
    // R10
    sp_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !$past(is_double) |-> result[63:32] == '0);

endmodule

// File: tb/sim_fp_int_bound_round.sv
`timescale 1ns/1ps
module sim_fp_int_bound_round;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [63:0] operand;
    logic        is_double, int64_sel, trunc_sel;
    logic [1:0]  rmode;
    logic        out_valid;
    logic [63:0] result;
    logic        flag_invalid, flag_inexact;

    int checks = 0;
    int errors = 0;
    logic [63:0] e_res;
    logic        e_inv, e_inx;

    always #2.5 clk = ~clk;

    fp_int_bound_round u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .is_double(is_double), .int64_sel(int64_sel), .trunc_sel(trunc_sel),
        .rmode(rmode), .out_valid(out_valid), .result(result),
        .flag_invalid(flag_invalid), .flag_inexact(flag_inexact)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    function automatic real sp_to_real(input logic [31:0] b);
        real m;
        if (b[30:23] == 8'd0)
            m = real'(b[22:0]) * (2.0 ** (-149.0));
        else
            m = (1.0 + real'(b[22:0]) / 8388608.0) * (2.0 ** real'(int'(b[30:23]) - 127));
        return b[31] ? -m : m;
    endfunction

    function automatic logic [31:0] real_to_sp(input real r);
        real m;
        int  e;
        m = (r < 0.0) ? -r : r;
        e = 127;
        while (m >= 2.0) begin
            m = m / 2.0;
            e++;
        end
        return {r < 0.0, 8'(e), 23'(longint'((m - 1.0) * 8388608.0))};
    endfunction

    function automatic real rnd_ref(input real x, input int md);
        real fl, d;
        fl = $floor(x);
        d  = x - fl;
        case (md)
            0: begin
                if (d > 0.5) return fl + 1.0;
                if (d < 0.5) return fl;
                return ($floor(fl / 2.0) == fl / 2.0) ? fl : fl + 1.0;
            end
            1: return $ceil(x);
            2: return fl;
            default: return (x < 0.0) ? $ceil(x) : fl;
        endcase
    endfunction

    task automatic ref_model(input logic [63:0] op, input bit dbl, input bit i64,
                             input bit tr, input logic [1:0] rm);
        int  n, md;
        bit  spc, sgn;
        real x, r, lo;
        n  = i64 ? 64 : 32;
        md = tr ? 3 : int'(rm);
        lo = -(2.0 ** real'(n - 1));
        if (dbl) begin
            spc = &op[62:52]; sgn = op[63];
            x = spc ? 0.0 : $bitstoreal(op);
        end else begin
            spc = &op[30:23]; sgn = op[31];
            x = spc ? 0.0 : sp_to_real(op[31:0]);
        end
        r = rnd_ref(x, md);
        if (spc || r < lo || r >= -lo) begin
            e_inv = 1'b1; e_inx = 1'b0;
            e_res = dbl ? $realtobits(lo) : {32'b0, real_to_sp(lo)};
        end else begin
            e_inv = 1'b0;
            e_inx = (r != x);
            if (r == 0.0)
                e_res = dbl ? {sgn, 63'b0} : {32'b0, sgn, 31'b0};
            else
                e_res = dbl ? $realtobits(r) : {32'b0, real_to_sp(r)};
        end
    endtask

    task automatic step(input bit v, input logic [63:0] op, input bit dbl, input bit i64,
                        input bit tr, input logic [1:0] rm, input string tag);
        in_valid = v; operand = op; is_double = dbl;
        int64_sel = i64; trunc_sel = tr; rmode = rm;
        if (v) ref_model(op, dbl, i64, tr, rm);
        @(negedge clk);
        chk(out_valid == v, "R1", "out_valid", 64'(out_valid), 64'(v));
        chk(result == e_res, tag, "result", result, e_res);
        chk(flag_invalid == e_inv, tag, "invalid", 64'(flag_invalid), 64'(e_inv));
        chk(flag_inexact == e_inx, tag, "inexact", 64'(flag_inexact), 64'(e_inx));
    endtask

    task automatic dstep(input real x, input bit i64, input bit tr,
                         input logic [1:0] rm, input string tag);
        step(1'b1, $realtobits(x), 1'b1, i64, tr, rm, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; operand = '0;
        is_double = 1'b0; int64_sel = 1'b0; trunc_sel = 1'b0; rmode = 2'd0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(out_valid == 1'b0, "R11", "out_valid", 64'(out_valid), 64'd0);
        chk(result == 64'd0, "R11", "result", result, 64'd0);
        chk(!flag_invalid && !flag_inexact, "R11", "flags",
            64'({flag_invalid, flag_inexact}), 64'd0);
        e_res = '0; e_inv = 1'b0; e_inx = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R7: ties to even
        dstep(2.5, 0, 0, 2'd0, "R7");
        dstep(3.5, 0, 0, 2'd0, "R7");
        dstep(-2.5, 0, 0, 2'd0, "R7");
        dstep(1.5, 0, 0, 2'd0, "R7");
        // R6: modes and the toward-zero variant
        dstep(2.5, 0, 0, 2'd1, "R6");
        dstep(-2.5, 0, 0, 2'd2, "R6");
        dstep(2.7, 0, 0, 2'd3, "R6");
        dstep(2.7, 0, 1, 2'd1, "R6");
        dstep(-2.7, 1, 1, 2'd2, "R6");
        // R9: magnitudes below one
        dstep(0.3, 0, 0, 2'd0, "R9");
        dstep(-0.3, 0, 0, 2'd1, "R9");
        dstep(0.3, 0, 0, 2'd1, "R9");
        dstep(-0.3, 0, 0, 2'd2, "R9");
        dstep(0.5, 0, 0, 2'd0, "R9");
        dstep(-0.7, 0, 0, 2'd0, "R9");
        // R8: exact values pass unchanged
        step(1'b1, 64'h8000_0000_0000_0000, 1'b1, 1'b0, 1'b0, 2'd1, "R8");
        dstep(5.0, 0, 0, 2'd2, "R8");
        dstep(-1.0e15, 1, 0, 2'd0, "R8");
        // R1: idle cycles hold the last result
        step(1'b0, 64'h4009_0000_0000_0000, 1'b1, 1'b0, 1'b0, 2'd0, "R1");
        step(1'b0, 64'h7ff0_0000_0000_0000, 1'b1, 1'b0, 1'b0, 2'd0, "R1");
        // R2: NaN and infinities
        step(1'b1, 64'h7ff8_0000_0000_0001, 1'b1, 1'b0, 1'b0, 2'd0, "R2");
        step(1'b1, 64'h7ff0_0000_0000_0000, 1'b1, 1'b1, 1'b0, 2'd0, "R2");
        step(1'b1, 64'hfff0_0000_0000_0000, 1'b1, 1'b0, 1'b1, 2'd0, "R2");
        step(1'b1, 64'h0000_0000_7fc0_0000, 1'b0, 1'b0, 1'b0, 2'd0, "R2");
        // R3 / R4 / R5: limits
        dstep(-2147483648.0, 0, 0, 2'd0, "R4");
        dstep(2147483648.0, 0, 0, 2'd0, "R4");
        dstep(-2147483648.5, 0, 0, 2'd0, "R3");
        dstep(2147483647.5, 0, 0, 2'd0, "R5");
        dstep(2147483647.5, 0, 0, 2'd3, "R3");
        dstep(-9223372036854775808.0, 1, 0, 2'd0, "R4");
        dstep(9223372036854775808.0, 1, 0, 2'd0, "R5");
        dstep(1.0e300, 1, 0, 2'd0, "R5");
        dstep(-2147483649.0, 0, 0, 2'd0, "R4");
        // R10: single precision
        step(1'b1, 64'hdead_beef_4020_0000, 1'b0, 1'b0, 1'b0, 2'd0, "R10");
        step(1'b1, 64'h0000_0000_cf00_0000, 1'b0, 1'b0, 1'b0, 2'd0, "R10");
        step(1'b1, 64'h0000_0000_4f00_0000, 1'b0, 1'b0, 1'b0, 2'd0, "R10");
        step(1'b1, 64'h0000_0000_4f00_0000, 1'b0, 1'b1, 1'b0, 2'd0, "R10");
        step(1'b1, 64'h1234_5678_3fc0_0000, 1'b0, 1'b0, 1'b0, 2'd0, "R10");
        step(1'b1, 64'h0000_0000_0000_0001, 1'b0, 1'b0, 1'b0, 2'd1, "R9");
        step(1'b1, 64'h0000_0000_5f00_0000, 1'b0, 1'b1, 1'b0, 2'd0, "R5");

        // R3: mixed operands across both precisions
        for (int i = 0; i < 80; i++) begin
            logic [63:0] fr;
            fr = {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) fr[39:0] = '0;
            step(1'b1, {fr[63], 11'(1020 + $urandom_range(0, 70)), fr[51:0]}, 1'b1,
                 1'($urandom), 1'($urandom_range(0, 3) == 0), 2'($urandom), "R3");
        end
        for (int i = 0; i < 80; i++) begin
            logic [63:0] fr;
            fr = {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) fr[15:0] = '0;
            step(($urandom_range(0, 7) != 0),
                 {fr[63:32], fr[31], 8'(124 + $urandom_range(0, 70)), fr[22:0]}, 1'b0,
                 1'($urandom), 1'($urandom_range(0, 3) == 0), 2'($urandom), "R10");
        end

        summary();
        $finish;
    end
endmodule